// File: doc/BRIEF.md
# ATA Task-File Address Mode Decoder

This block sits between the host side of a removable ATA storage card and the card's ATA core. It takes a host offset from either common memory or I/O space and turns it into a 4-bit task-file register index. Which address windows are recognised depends on a mode field kept in the card's option register. Accesses that reach the ATA core come out as a core index, read and write strobes, and a flag that marks 16-bit data-port transfers. A few high indices are handled inside the block and never reach the core: the alternate status view, the device-control register, the device-address register and the odd-byte data path.

The decoder itself is combinational from address to strobes. The only state it keeps is the device-control register, a latched data word with its byte-phase flag, and a one-cycle soft-reset request. A write to an ordinary forwarded register while the card is powered down also raises a wake request. Outside logic uses that request to clear the power-down status bit and to set the ready flag.

Top module: `ata_taskfile_decoder`

## Requirements
- R1: With mode 0 (memory mapped), any offset from 0x400 to 0x7FF selects index 0, the 16-bit data port.
- R2: With mode 1 (contiguous I/O), the index is the offset's low four bits and every offset is valid.
- R3: With mode 2 (primary I/O), offsets 0x1F0..0x1FF map to 0x0..0xF and offsets 0x3F0..0x3FF map to offset minus 0x3E8 (0x3F6 gives 0xE, 0x3F7 gives 0xF).
- R4: With mode 3 (secondary I/O), offsets 0x170..0x17F map to 0x0..0xF and offsets 0x370..0x37F map to offset minus 0x368 (0x376 gives 0xE).
- R5: An offset outside every window of the current mode keeps its value. This also holds for any mode value above 3. If the result is above 0xF, no core strobe fires and a read returns 0.
- R6: Indices 0x0 and 0x8 raise core_rd or core_wr with core_wide=1 and core_idx=0. A read returns the full 16-bit core word, and that word is also latched.
- R7: A read of index 0x9 returns the latched word's high byte in bits 7:0. A write of index 0x9 loads the latch with {0x00, write bits 7:0} and toggles byte_phase. Neither access strobes the core.
- R8: Index 0xD is forwarded to core register 1 for both reads (error) and writes (features).
- R9: A read of index 0xE returns core_status, or 0 when drive_present is low, without a core strobe. A write of index 0xE loads devctl from write bits 7:0 without a core strobe. If write bit 2 is set, soft_reset_req is high for the single following cycle.
- R10: A read of index 0xF returns 0xC2 | ((~drive_sel << 2) & 0x3C), which is 0xFE for drive_sel=0 and 0xFA for drive_sel=1, with no core strobe.
- R11: Indices 0x1-0x7 and 0xA-0xC are forwarded with core_idx equal to the index, and 8-bit reads return the core byte zero-extended. A write to one of these indices asserts wake_req in the same cycle exactly when pwrdn_active is high.
- R12: After reset, devctl, byte_phase, soft_reset_req and the latched word are all zero. host_rdata is 0 whenever host_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host offset into memory or I/O space |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | DATA_W | Host write data |
| mode_sel | input | MODE_W | Addressing mode field from the option register |
| core_rdata | input | DATA_W | Read data from the ATA core |
| core_status | input | 8 | Current ATA core status byte |
| drive_present | input | 1 | A drive is attached |
| drive_sel | input | 1 | Currently selected drive |
| pwrdn_active | input | 1 | Card power-down status bit |
| core_idx | output | 4 | Core register index |
| core_rd | output | 1 | Core read strobe |
| core_wr | output | 1 | Core write strobe |
| core_wide | output | 1 | Access is to the 16-bit data port |
| core_wdata | output | DATA_W | Write data to the core |
| host_rdata | output | DATA_W | Read data returned to the host |
| devctl | output | 8 | Device-control register |
| byte_phase | output | 1 | Odd-byte phase flag |
| soft_reset_req | output | 1 | One-cycle soft-reset request |
| wake_req | output | 1 | Request to leave power-down |

## Verification
The bench walks every mode across the edges of its windows. It includes offsets that map just past 0xF, such as 0x3F8 in primary mode, and offsets that belong to the other mode's windows. A decoder with an off-by-one window or a wrong subtrahend would either strobe the wrong register or strobe the core when it should not. The bench checks that the alternate-status read leaves core_rd low and returns 0 with no drive present; a design that forwarded it would clear a pending interrupt. It also runs the latch sequence, a wide read then an odd-byte read then an odd-byte write, where a mis-sliced or unlatched word shows up as a wrong byte. It checks the one-cycle soft-reset pulse, and that wake_req appears only on ordinary forwarded writes while power-down is set.

// File: rtl/ata_tf_pkg.sv
`timescale 1ns/1ps
package ata_tf_pkg;
   localparam int TF_IDX_W = 4;
   localparam int BYTE_W   = 8;

   localparam logic [TF_IDX_W-1:0] IDX_DATA     = 4'h0;
   localparam logic [TF_IDX_W-1:0] IDX_DATA_ALT = 4'h8;
   localparam logic [TF_IDX_W-1:0] IDX_ODD      = 4'h9;
   localparam logic [TF_IDX_W-1:0] IDX_ERRFEAT  = 4'hD;
   localparam logic [TF_IDX_W-1:0] IDX_ALTSTAT  = 4'hE;
   localparam logic [TF_IDX_W-1:0] IDX_DEVADDR  = 4'hF;
   localparam logic [TF_IDX_W-1:0] CORE_ERRFEAT = 4'h1;

   localparam logic [BYTE_W-1:0] DEVADDR_BASE = 8'hC2;
   localparam logic [BYTE_W-1:0] DEVADDR_MASK = 8'h3C;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_WIDE,
      ACC_BYTE,
      ACC_ODD,
      ACC_ALT,
      ACC_DADDR
   } acc_kind_e;
endpackage

// File: rtl/tf_addr_remap.sv
`timescale 1ns/1ps
module tf_addr_remap
   import ata_tf_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int MODE_W       = 6,
   parameter int MEM_SHIFT    = 10,
   parameter int PRI_CMD_BASE = 'h1F0,
   parameter int PRI_CTL_BASE = 'h3F0,
   parameter int SEC_CMD_BASE = 'h170,
   parameter int SEC_CTL_BASE = 'h370
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic [MODE_W-1:0]   mode,
   output logic [TF_IDX_W-1:0] idx,
   output logic                idx_ok
);
   localparam int N_WIN   = 4;
   localparam int WIN_LSB = TF_IDX_W;
   localparam int CTL_OFF = 8;

   localparam logic [MODE_W-1:0] MODE_MEM  = MODE_W'(0);
   localparam logic [MODE_W-1:0] MODE_IO16 = MODE_W'(1);
   localparam logic [MODE_W-1:0] MODE_PRI  = MODE_W'(2);
   localparam logic [MODE_W-1:0] MODE_SEC  = MODE_W'(3);

   localparam int WIN_BASE [N_WIN] = '{PRI_CMD_BASE, PRI_CTL_BASE, SEC_CMD_BASE, SEC_CTL_BASE};
   localparam int WIN_OFF  [N_WIN] = '{0, CTL_OFF, 0, CTL_OFF};

   generate
      if (ADDR_W <= MEM_SHIFT + 1 || ADDR_W > 32) begin : g_bad_addr
         $error("tf_addr_remap: ADDR_W must exceed MEM_SHIFT+1 and be at most 32");
      end
      if (MODE_W < 2) begin : g_bad_mode
         $error("tf_addr_remap: MODE_W must be at least 2");
      end
   endgenerate

   logic [N_WIN-1:0]  win_hit;
   logic [ADDR_W-1:0] win_map [N_WIN];

   for (genvar w = 0; w < N_WIN; w++) begin : g_win
      localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASE[w]);
      localparam logic [ADDR_W-1:0] OFF  = ADDR_W'(WIN_OFF[w]);
      assign win_hit[w] = (addr[ADDR_W-1:WIN_LSB] == BASE[ADDR_W-1:WIN_LSB]);
      assign win_map[w] = addr - BASE + OFF;
   end

   logic              mem_hit;
   logic [ADDR_W-1:0] mapped;

   assign mem_hit = (addr[ADDR_W-1:MEM_SHIFT] == (ADDR_W-MEM_SHIFT)'(1));

   always_comb begin
      mapped = addr;
      case (mode)
         MODE_MEM:  if (mem_hit) mapped = '0;
         MODE_IO16: mapped = {{(ADDR_W-TF_IDX_W){1'b0}}, addr[TF_IDX_W-1:0]};
         MODE_PRI: begin
            if (win_hit[1])      mapped = win_map[1];
            else if (win_hit[0]) mapped = win_map[0];
         end
         MODE_SEC: begin
            if (win_hit[3])      mapped = win_map[3];
            else if (win_hit[2]) mapped = win_map[2];
         end
         default: mapped = addr;
      endcase
   end

   assign idx_ok = (mapped[ADDR_W-1:TF_IDX_W] == '0);
   assign idx    = mapped[TF_IDX_W-1:0];
endmodule

// File: rtl/tf_access_router.sv
`timescale 1ns/1ps
module tf_access_router
   import ata_tf_pkg::*;
(
   input  logic                rd,
   input  logic                wr,
   input  logic [TF_IDX_W-1:0] idx,
   input  logic                idx_ok,
   input  logic                pwrdn,
   output acc_kind_e           kind,
   output logic                core_rd,
   output logic                core_wr,
   output logic                core_wide,
   output logic [TF_IDX_W-1:0] core_idx,
   output logic                rd_wide,
   output logic                wr_odd,
   output logic                wr_ctrl,
   output logic                wake
);
   logic fwd;

   always_comb begin
      kind = ACC_NONE;
      if (idx_ok) begin
         case (idx)
            IDX_DATA, IDX_DATA_ALT: kind = ACC_WIDE;
            IDX_ODD:                kind = ACC_ODD;
            IDX_ALTSTAT:            kind = ACC_ALT;
            IDX_DEVADDR:            kind = ACC_DADDR;
            default:                kind = ACC_BYTE;
         endcase
      end
   end

   always_comb begin
      core_idx = idx;
      if (kind == ACC_WIDE)      core_idx = IDX_DATA;
      else if (idx == IDX_ERRFEAT) core_idx = CORE_ERRFEAT;
   end

   assign fwd       = (kind == ACC_WIDE) || (kind == ACC_BYTE);
   assign core_rd   = rd & fwd;
   assign core_wr   = wr & fwd;
   assign core_wide = (kind == ACC_WIDE);
   assign rd_wide   = rd & (kind == ACC_WIDE);
   assign wr_odd    = wr & (kind == ACC_ODD);
   assign wr_ctrl   = wr & (kind == ACC_ALT);
   assign wake      = wr & pwrdn & (kind == ACC_BYTE) & (idx != IDX_ERRFEAT);
endmodule

// File: rtl/tf_local_regs.sv
`timescale 1ns/1ps
module tf_local_regs
   import ata_tf_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int SOFT_RST_REG = 1,
   parameter int SRST_BIT     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_wide,
   input  logic              wr_odd,
   input  logic              wr_ctrl,
   input  logic [BYTE_W-1:0] wbyte,
   input  logic [DATA_W-1:0] core_rdata,
   output logic [DATA_W-1:0] latch_word,
   output logic              byte_phase,
   output logic [BYTE_W-1:0] devctl,
   output logic              soft_reset_req
);
   generate
      if (SRST_BIT >= BYTE_W) begin : g_bad_bit
         $error("tf_local_regs: SRST_BIT outside device-control byte");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_word <= '0;
         byte_phase <= 1'b0;
         devctl     <= '0;
      end else begin
         if (rd_wide) latch_word <= core_rdata;
         if (wr_odd) begin
            latch_word <= {{(DATA_W-BYTE_W){1'b0}}, wbyte};
            byte_phase <= ~byte_phase;
         end
         if (wr_ctrl) devctl <= wbyte;
      end
   end

   generate
      if (SOFT_RST_REG != 0) begin : g_srst_reg
         always_ff @(posedge clk) begin
            if (!rst_n) soft_reset_req <= 1'b0;
            else        soft_reset_req <= wr_ctrl & wbyte[SRST_BIT];
         end
      end else begin : g_srst_comb
         assign soft_reset_req = wr_ctrl & wbyte[SRST_BIT];
      end
   endgenerate
endmodule

// File: rtl/ata_taskfile_decoder.sv
`timescale 1ns/1ps
module ata_taskfile_decoder
   import ata_tf_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 16,
   parameter int MODE_W       = 6,
   parameter int SOFT_RST_REG = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   host_addr,
   input  logic                host_rd,
   input  logic                host_wr,
   input  logic [DATA_W-1:0]   host_wdata,
   input  logic [MODE_W-1:0]   mode_sel,
   input  logic [DATA_W-1:0]   core_rdata,
   input  logic [7:0]          core_status,
   input  logic                drive_present,
   input  logic                drive_sel,
   input  logic                pwrdn_active,
   output logic [3:0]          core_idx,
   output logic                core_rd,
   output logic                core_wr,
   output logic                core_wide,
   output logic [DATA_W-1:0]   core_wdata,
   output logic [DATA_W-1:0]   host_rdata,
   output logic [7:0]          devctl,
   output logic                byte_phase,
   output logic                soft_reset_req,
   output logic                wake_req
);
   localparam int PAD_W = DATA_W - BYTE_W;

   generate
      if (DATA_W != 2 * BYTE_W) begin : g_bad_data
         $error("ata_taskfile_decoder: DATA_W must be two bytes");
      end
   endgenerate

   logic [TF_IDX_W-1:0] idx;
   logic                idx_ok;
   acc_kind_e           kind;
   logic                rd_wide, wr_odd, wr_ctrl;
   logic [DATA_W-1:0]   latch_word;
   logic [BYTE_W-1:0]   daddr_byte;
   logic [BYTE_W-1:0]   sel_ext;

   tf_addr_remap #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) remap_i (
      .addr   (host_addr),
      .mode   (mode_sel),
      .idx    (idx),
      .idx_ok (idx_ok)
   );

   tf_access_router router_i (
      .rd        (host_rd),
      .wr        (host_wr),
      .idx       (idx),
      .idx_ok    (idx_ok),
      .pwrdn     (pwrdn_active),
      .kind      (kind),
      .core_rd   (core_rd),
      .core_wr   (core_wr),
      .core_wide (core_wide),
      .core_idx  (core_idx),
      .rd_wide   (rd_wide),
      .wr_odd    (wr_odd),
      .wr_ctrl   (wr_ctrl),
      .wake      (wake_req)
   );

   tf_local_regs #(.DATA_W(DATA_W), .SOFT_RST_REG(SOFT_RST_REG)) regs_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .rd_wide        (rd_wide),
      .wr_odd         (wr_odd),
      .wr_ctrl        (wr_ctrl),
      .wbyte          (host_wdata[BYTE_W-1:0]),
      .core_rdata     (core_rdata),
      .latch_word     (latch_word),
      .byte_phase     (byte_phase),
      .devctl         (devctl),
      .soft_reset_req (soft_reset_req)
   );

   assign core_wdata = host_wdata;
   assign sel_ext    = ~{{(BYTE_W-1){1'b0}}, drive_sel};
   assign daddr_byte = DEVADDR_BASE | ((sel_ext << 2) & DEVADDR_MASK);

   always_comb begin
      host_rdata = '0;
      if (host_rd) begin
         case (kind)
            ACC_WIDE:  host_rdata = core_rdata;
            ACC_BYTE:  host_rdata = {{PAD_W{1'b0}}, core_rdata[BYTE_W-1:0]};
            ACC_ODD:   host_rdata = {{PAD_W{1'b0}}, latch_word[DATA_W-1:BYTE_W]};
            ACC_ALT:   host_rdata = drive_present ? {{PAD_W{1'b0}}, core_status} : '0;
            ACC_DADDR: host_rdata = {{PAD_W{1'b0}}, daddr_byte};
            default:   host_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/tf_decoder_chk.sv
`timescale 1ns/1ps
module tf_decoder_chk #(
   parameter int DATA_W       = 16,
   parameter int SOFT_RST_REG = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_rd,
   input logic              host_wr,
   input logic              srst_bit,
   input logic [3:0]        idx,
   input logic              idx_ok,
   input logic              core_rd,
   input logic              core_wr,
   input logic              wake_req,
   input logic              byte_phase,
   input logic              soft_reset_req,
   input logic [DATA_W-1:0] host_rdata
);
   // R5
   invalid_idx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !idx_ok |-> (!core_rd && !core_wr));
   // R5
   invalid_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !idx_ok) |-> (host_rdata == '0));
   // R7
   odd_phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && idx_ok && idx == 4'h9) |=> (byte_phase != $past(byte_phase)));
   // R9
   ctrl_local_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_ok && (idx == 4'hE || idx == 4'hF || idx == 4'h9)) |-> (!core_rd && !core_wr));
   // R11
   wake_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> core_wr);
   generate
      if (SOFT_RST_REG != 0) begin : g_srst
         // R9
         srst_follows_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && idx_ok && idx == 4'hE && srst_bit) |=> soft_reset_req);
         // R9
         srst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            soft_reset_req |-> $past(host_wr && idx_ok && idx == 4'hE && srst_bit));
      end
   endgenerate
endmodule

bind ata_taskfile_decoder tf_decoder_chk #(.DATA_W(DATA_W), .SOFT_RST_REG(SOFT_RST_REG)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .host_rd        (host_rd),
   .host_wr        (host_wr),
   .srst_bit       (host_wdata[2]),
   .idx            (idx),
   .idx_ok         (idx_ok),
   .core_rd        (core_rd),
   .core_wr        (core_wr),
   .wake_req       (wake_req),
   .byte_phase     (byte_phase),
   .soft_reset_req (soft_reset_req),
   .host_rdata     (host_rdata)
);

// File: tb/ata_taskfile_decoder_tb.sv
`timescale 1ns/1ps
module ata_taskfile_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] host_addr = '0;
   logic        host_rd = 1'b0, host_wr = 1'b0;
   logic [15:0] host_wdata = '0;
   logic [5:0]  mode_sel = '0;
   logic [15:0] core_rdata = '0;
   logic [7:0]  core_status = '0;
   logic        drive_present = 1'b0, drive_sel = 1'b0, pwrdn_active = 1'b0;
   logic [3:0]  core_idx;
   logic        core_rd, core_wr, core_wide;
   logic [15:0] core_wdata, host_rdata;
   logic [7:0]  devctl;
   logic        byte_phase, soft_reset_req, wake_req;

   int n_run = 0;
   int n_fail = 0;

   // behavioural model state
   logic [15:0] m_latch = '0;
   logic        m_phase = 1'b0;
   logic [7:0]  m_ctrl = '0;
   logic        m_srst = 1'b0;

   always #2 clk = ~clk;

   ata_taskfile_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
      .host_wr(host_wr), .host_wdata(host_wdata), .mode_sel(mode_sel),
      .core_rdata(core_rdata), .core_status(core_status),
      .drive_present(drive_present), .drive_sel(drive_sel),
      .pwrdn_active(pwrdn_active), .core_idx(core_idx), .core_rd(core_rd),
      .core_wr(core_wr), .core_wide(core_wide), .core_wdata(core_wdata),
      .host_rdata(host_rdata), .devctl(devctl), .byte_phase(byte_phase),
      .soft_reset_req(soft_reset_req), .wake_req(wake_req)
   );

   function automatic int decode(int a, int m);
      int r;
      r = a;
      if (m == 0 && a >= 1024 && a < 2048) r = 0;
      else if (m == 1) r = a % 16;
      else if (m == 2 && a >= 496 && a <= 511) r = a - 496;
      else if (m == 2 && a >= 1008 && a <= 1023) r = a - 1000;
      else if (m == 3 && a >= 368 && a <= 383) r = a - 368;
      else if (m == 3 && a >= 880 && a <= 895) r = a - 872;
      return (r < 16) ? r : -1;
   endfunction

   function automatic bit is_fwd(int i);
      return (i >= 0) && (i != 9) && (i != 14) && (i != 15);
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // model update on each clock
   always @(posedge clk) begin
      int i;
      i = decode(int'(host_addr), int'(mode_sel));
      if (!rst_n) begin
         m_latch = '0; m_phase = 1'b0; m_ctrl = '0; m_srst = 1'b0;
      end else begin
         m_srst = host_wr && i == 14 && host_wdata[2];
         if (host_rd && (i == 0 || i == 8)) m_latch = core_rdata;
         if (host_wr && i == 9) begin
            m_latch = {8'h00, host_wdata[7:0]};
            m_phase = ~m_phase;
         end
         if (host_wr && i == 14) m_ctrl = host_wdata[7:0];
      end
   end

   // per-clock comparison of registered outputs (R7 R9 R12)
   always @(negedge clk) begin
      if (rst_n) begin
         check(devctl == m_ctrl, "R9", "devctl", int'(devctl), int'(m_ctrl));
         check(byte_phase == m_phase, "R7", "byte_phase", int'(byte_phase), int'(m_phase));
         check(soft_reset_req == m_srst, "R9", "soft_reset_req", int'(soft_reset_req), int'(m_srst));
      end
   end

   task automatic op(bit rd, bit wr, int a, logic [15:0] wd, string tag);
      int i;
      logic [15:0] er;
      @(negedge clk);
      host_rd = rd; host_wr = wr; host_addr = 12'(a); host_wdata = wd;
      #0.5;
      i = decode(a, int'(mode_sel));
      check(core_rd == (rd && is_fwd(i)), tag, "core_rd", int'(core_rd), int'(rd && is_fwd(i)));
      check(core_wr == (wr && is_fwd(i)), tag, "core_wr", int'(core_wr), int'(wr && is_fwd(i)));
      if (is_fwd(i)) begin
         int ei;
         ei = (i == 8) ? 0 : (i == 13) ? 1 : i;
         check(int'(core_idx) == ei, tag, "core_idx", int'(core_idx), ei);
         check(core_wide == (i == 0 || i == 8), tag, "core_wide", int'(core_wide), int'(i == 0 || i == 8));
      end
      if (wr) check(core_wdata == wd, tag, "core_wdata", int'(core_wdata), int'(wd));
      check(wake_req == (wr && pwrdn_active && is_fwd(i) && i != 0 && i != 8 && i != 13),
            tag, "wake_req", int'(wake_req),
            int'(wr && pwrdn_active && is_fwd(i) && i != 0 && i != 8 && i != 13));
      er = '0;
      if (rd) begin
         if (i == 0 || i == 8) er = core_rdata;
         else if (i == 9) er = {8'h00, m_latch[15:8]};
         else if (i == 14) er = drive_present ? {8'h00, core_status} : 16'h0;
         else if (i == 15) er = drive_sel ? 16'h00FA : 16'h00FE;
         else if (i >= 0) er = {8'h00, core_rdata[7:0]};
      end
      check(host_rdata == er, tag, "host_rdata", int'(host_rdata), int'(er));
   endtask

   task automatic idle();
      @(negedge clk);
      host_rd = 1'b0; host_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12 reset state
      check(devctl == 8'h00, "R12", "reset devctl", int'(devctl), 0);
      check(byte_phase == 1'b0, "R12", "reset byte_phase", int'(byte_phase), 0);
      check(soft_reset_req == 1'b0, "R12", "reset soft_reset_req", int'(soft_reset_req), 0);
      check(host_rdata == 16'h0, "R12", "idle rdata", int'(host_rdata), 0);
      rst_n = 1'b1;

      core_rdata = 16'hA55A; core_status = 8'h50; drive_present = 1'b1;
      // R1 memory mapped
      mode_sel = 6'd0;
      op(1, 0, 'h400, 16'h0, "R1");
      op(0, 1, 'h7FF, 16'hBEEF, "R1");
      op(1, 0, 'h5A3, 16'h0, "R1");
      op(1, 0, 'h00D, 16'h0, "R8");
      op(1, 0, 'h3FF, 16'h0, "R5");
      op(1, 0, 'h800, 16'h0, "R5");
      pwrdn_active = 1'b1;
      op(0, 1, 'h002, 16'h0011, "R11");
      op(0, 1, 'h00D, 16'h0022, "R8");
      op(0, 1, 'h008, 16'h1357, "R6");
      pwrdn_active = 1'b0;
      op(0, 1, 'h003, 16'h0033, "R11");

      // R2 contiguous
      mode_sel = 6'd1;
      op(1, 0, 'h123, 16'h0, "R2");
      op(1, 0, 'hFFE, 16'h0, "R9");
      drive_present = 1'b0;
      op(1, 0, 'h7FE, 16'h0, "R9");
      drive_present = 1'b1;
      op(1, 0, 'h0AF, 16'h0, "R10");
      drive_sel = 1'b1;
      op(1, 0, 'h00F, 16'h0, "R10");
      drive_sel = 1'b0;
      // R6 R7 latch sequence
      core_rdata = 16'hC3E1;
      op(1, 0, 'h000, 16'h0, "R6");
      op(1, 0, 'h009, 16'h0, "R7");
      op(0, 1, 'h009, 16'h1234, "R7");
      op(1, 0, 'h009, 16'h0, "R7");
      op(0, 1, 'h019, 16'h00FF, "R7");
      op(1, 0, 'h00A, 16'h0, "R11");

      // R3 primary
      mode_sel = 6'd2;
      op(1, 0, 'h1F7, 16'h0, "R3");
      op(1, 0, 'h1F0, 16'h0, "R3");
      op(1, 0, 'h3F6, 16'h0, "R3");
      op(1, 0, 'h3F7, 16'h0, "R3");
      op(1, 0, 'h3F8, 16'h0, "R5");
      op(0, 1, 'h3F8, 16'h0004, "R5");
      op(1, 0, 'h170, 16'h0, "R5");
      op(0, 1, 'h3F6, 16'h0004, "R9");
      op(0, 1, 'h3F6, 16'h0002, "R9");
      op(0, 1, 'h3F6, 16'h00FF, "R9");
      op(0, 1, 'h3F6, 16'h0000, "R9");

      // R4 secondary
      mode_sel = 6'd3;
      op(1, 0, 'h171, 16'h0, "R4");
      op(1, 0, 'h17C, 16'h0, "R4");
      op(1, 0, 'h376, 16'h0, "R4");
      op(1, 0, 'h377, 16'h0, "R4");
      op(1, 0, 'h1F1, 16'h0, "R5");
      pwrdn_active = 1'b1;
      op(0, 1, 'h176, 16'h0077, "R11");
      op(0, 1, 'h376, 16'h0006, "R4");
      pwrdn_active = 1'b0;

      // R5 unknown mode: pass-through
      mode_sel = 6'd5;
      op(1, 0, 'h00C, 16'h0, "R5");
      op(1, 0, 'h400, 16'h0, "R5");
      op(1, 0, 'h00E, 16'h0, "R5");
      idle();
      repeat (3) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule